// File: doc/BRIEF.md
# I2C Target Address Receiver

This block is the receive side of an I2C target that runs entirely from a fast system clock. The raw SCL and SDA pins pass through a synchronizer first. The block then oversamples the two lines to find bus conditions, clock edges and data bits. After a START it collects the first byte MSB first and splits it into a 7-bit address and a direction bit. It compares the address against a local address supplied on an input.

When the address matches, the block pulls SDA low through an open-drain output enable during the ninth SCL clock. For a write it then accepts data bytes and acknowledges each one. Each byte appears on `rx_data` together with a one-cycle `rx_valid` strobe. A mismatching address leaves the line released until the bus shows the next START or STOP. A START that arrives part-way through a byte throws that byte away and begins address reception again.

Top module: `i2c_addr_target`

## Requirements
- R1: While reset is high and in the first cycle after it, `sda_oe`, `busy` and `rx_valid` are all 0.
- R2: An SDA fall while SCL is high (START) sets `busy`. An SDA rise while SCL is high (STOP) clears `busy` and releases `sda_oe`.
- R3: The first byte after START is taken MSB first, one bit per SCL rising edge. Bits 7..1 of the byte form the address and bit 0 gives the direction (0 = write, 1 = read). When bits 7..1 equal `own_addr`, `sda_oe` is 1 throughout the ninth SCL high phase, so the bus reads 0 (acknowledge).
- R4: On an address mismatch, `sda_oe` stays 0 and `rx_valid` never pulses until the next START or STOP.
- R5: After a matched write address, each further 8-bit byte is acknowledged in its ninth clock. Its value (MSB first) appears on `rx_data` with `rx_valid` high for exactly one system clock.
- R6: After a matched read address, the address is acknowledged. Later bytes get no acknowledge and produce no `rx_valid`.
- R7: A START received in the middle of a byte discards the partial byte and restarts address reception.
- R8: `sda_oe` changes only while the synchronized SCL is low. It is 1 only during acknowledge slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Local target address |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level (wired bus value) |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release |
| rx_data | output | 8 | Last received write data byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| busy | output | 1 | High from START until STOP |

## Verification
The bench builds the block with its default two-stage synchronizer. It runs SCL at a quarter period of ten system clocks, which leaves enough margin for the three-cycle detection latency inside each SCL phase. It changes `own_addr` between 0x42 and 0x7F at run time. This brings the address boundaries 0x00 and 0x7F and the all-zero and all-one data bytes within reach. It also exercises repeated START after a full byte, after part of a byte and after a mismatch.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_DATA,
        ST_ACK_DATA,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic scl;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] first_byte,
                                      input logic [ADDR_W-1:0] local_addr);
        return first_byte[BYTE_W-1 -: ADDR_W] == local_addr;
    endfunction

    function automatic logic wants_read(input logic [BYTE_W-1:0] first_byte);
        return first_byte[0];
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [ADDR_W-1:0] own_addr,
    output tgt_state_e        state,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy
);
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              dir_rd;
    logic              byte_done;
    logic              take_bit;

    assign take_bit  = evt.scl_rise && (bit_cnt < CNT_W'(BYTE_W));
    assign byte_done = evt.scl_fall && (bit_cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            dir_rd   <= 1'b0;
            sda_oe   <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            busy     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (evt.stop) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                busy    <= 1'b0;
                bit_cnt <= '0;
            end else if (evt.start) begin
                state   <= ST_ADDR;
                sda_oe  <= 1'b0;
                busy    <= 1'b1;
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_DATA: begin
                        if (take_bit) begin
                            shreg   <= {shreg[BYTE_W-2:0], evt.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg, own_addr)) begin
                                    dir_rd <= wants_read(shreg);
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK_ADDR;
                                end else begin
                                    state  <= ST_IGNORE;
                                end
                            end else begin
                                rx_data  <= shreg;
                                rx_valid <= 1'b1;
                                sda_oe   <= 1'b1;
                                state    <= ST_ACK_DATA;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= dir_rd ? ST_IGNORE : ST_DATA;
                        end
                    end
                    ST_ACK_DATA: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_DATA;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_addr_target.sv
module i2c_addr_target
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              busy
);
    logic [1:0] sync_bus;
    logic       scl_sync, sda_sync;
    logic       start_det, stop_det;
    bus_evt_t   bus_evt;
    tgt_state_e fsm_state;

    i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw    ({scl_in, sda_in}),
        .synced (sync_bus)
    );

    assign scl_sync = sync_bus[1];
    assign sda_sync = sync_bus[0];

    i2c_tgt_cond cond_i (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_sync),
        .sda_s (sda_sync),
        .evt   (bus_evt)
    );

    assign start_det = bus_evt.start;
    assign stop_det  = bus_evt.stop;

    i2c_tgt_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (bus_evt),
        .own_addr (own_addr),
        .state    (fsm_state),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .busy     (busy)
    );
endmodule

// File: rtl/i2c_addr_target_chk.sv
module i2c_addr_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input tgt_state_e state,
    input logic       sda_oe,
    input logic       rx_valid,
    input logic       busy
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sda_oe && !busy && !rx_valid));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_det && !stop_det) |=> busy);

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (!busy && !sda_oe));

    // R4
    ignore_released_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R5
    valid_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> sda_oe);

    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

bind i2c_addr_target i2c_addr_target_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_sync),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (fsm_state),
    .sda_oe    (sda_oe),
    .rx_valid  (rx_valid),
    .busy      (busy)
);

// File: tb/i2c_addr_target_tb.sv
module i2c_addr_target_tb_top;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] own_addr = 7'h42;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe, rx_valid, busy;
    logic [7:0] rx_data;

    int  n_chk = 0;
    int  n_fail = 0;
    int  stray_oe = 0;
    int  dbl_valid = 0;
    bit  in_ack = 1'b0;
    bit  done = 1'b0;
    bit  prev_valid = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_addr_target dut_i (
        .clk      (clk),
        .rst      (rst),
        .own_addr (own_addr),
        .scl_in   (m_scl),
        .sda_in   (sda_bus),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .busy     (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
    endtask

    // reference model: per-clock observation of strobes and drive
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe && !in_ack) stray_oe++;
            if (rx_valid && prev_valid) dbl_valid++;
            if (rx_valid) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R4/R6", "unexpected rx_valid", rx_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R5", "rx_data", rx_data, e);
                end
            end
            prev_valid = rx_valid;
        end
    end

    task automatic bus_start();
        if (!m_scl) begin
            m_sda = 1'b1; wq(Q);
            m_scl = 1'b1; wq(Q);
        end
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = v[i]; wq(Q);
            m_scl = 1'b1; wq(2 * Q);
            m_scl = 1'b0;
            if (i == 0) in_ack = 1'b1;
            wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        send_bits(v, 8);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        #1 ack = sda_bus;
        wq(Q);
        m_scl = 1'b0; wq(Q);
        in_ack = 1'b0;
    endtask

    task automatic byte_exp(input logic [7:0] v, input logic exp_ack,
                            input bit push, input string req);
        logic a;
        if (push) exp_q.push_back(v);
        send_byte(v, a);
        chk(a == exp_ack, req, $sformatf("ack bit for byte 0x%0h", v), a, exp_ack);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        chk(!sda_oe && !busy && !rx_valid, "R1", "outputs in reset",
            {sda_oe, busy, rx_valid}, 0);
        @(posedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk(!sda_oe && !busy && !rx_valid, "R1", "outputs after reset",
            {sda_oe, busy, rx_valid}, 0);
        wq(Q);

        // matched write with two bytes
        bus_start();
        chk(busy == 1'b1, "R2", "busy after START", busy, 1);
        byte_exp({7'h42, 1'b0}, 1'b0, 0, "R3");
        byte_exp(8'hA5, 1'b0, 1, "R5");
        byte_exp(8'h3C, 1'b0, 1, "R5");
        bus_stop();
        chk(busy == 1'b0 && sda_oe == 1'b0, "R2", "busy after STOP", busy, 0);

        // mismatch: no ack, data ignored
        bus_start();
        byte_exp({7'h43, 1'b0}, 1'b1, 0, "R4");
        byte_exp(8'h11, 1'b1, 0, "R4");
        chk(busy == 1'b1, "R2", "busy held during ignored transfer", busy, 1);
        bus_stop();

        // matched read: address acked, following byte not
        bus_start();
        byte_exp({7'h42, 1'b1}, 1'b0, 0, "R6");
        byte_exp(8'hFF, 1'b1, 0, "R6");
        bus_stop();

        // repeated START mid byte and after a full byte
        bus_start();
        byte_exp({7'h42, 1'b0}, 1'b0, 0, "R3");
        byte_exp(8'h5A, 1'b0, 1, "R5");
        send_bits(8'h00, 3);
        bus_start();
        chk(busy == 1'b1, "R7", "busy across repeated START", busy, 1);
        byte_exp({7'h42, 1'b0}, 1'b0, 0, "R7");
        byte_exp(8'h81, 1'b0, 1, "R7");
        bus_start();
        byte_exp({7'h42, 1'b0}, 1'b0, 0, "R7");
        byte_exp(8'h7E, 1'b0, 1, "R5");
        bus_stop();

        // boundary addresses
        own_addr = 7'h7F;
        wq(Q);
        bus_start();
        byte_exp({7'h00, 1'b0}, 1'b1, 0, "R4");
        byte_exp(8'h00, 1'b1, 0, "R4");
        bus_start();
        byte_exp({7'h7F, 1'b0}, 1'b0, 0, "R3");
        byte_exp(8'h00, 1'b0, 1, "R5");
        byte_exp(8'hFF, 1'b0, 1, "R5");
        bus_stop();

        wq(4 * Q);
        chk(exp_q.size() == 0, "R5", "bytes left unreceived", exp_q.size(), 0);
        chk(stray_oe == 0, "R8", "cycles of sda_oe outside ack slot", stray_oe, 0);
        chk(dbl_valid == 0, "R5", "rx_valid wider than one cycle", dbl_valid, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule